// File: doc/BRIEF.md
# Two-Alarm Time Field Comparator

This block watches the running time of day and calendar and compares it with two alarm register sets that work on their own. Each set holds one compare byte for each time field, plus a mask byte that chooses which fields take part in the comparison. A set can compare against one field, any group of fields, or all seven. The comparison happens only on the one-second tick. The block assumes the time fields already hold the new second when the tick is high, so a match gives one event per tick.

Each alarm has a status flag that software can poll. One active-low interrupt line combines both alarms. The line has two modes. In latched mode it stays low while any flag is set, and software clears a flag by writing zero to its bit. In pulse mode it goes low for one clock after a matching tick. Pulse mode suits periodic alarms: an alarm that compares only seconds fires once a minute. The time counters and the serial bus sit outside this block.

The time input is a packed bus with one BCD byte per field. Field index 0 is seconds, then minutes, hours, date, month, year, and index 6 is day of week. Field f occupies bits [8f+7:8f].

Top module: `alarm_match_unit`

## Requirements
- R1: During reset and right after it, both flags read 0, `irq_n_o` is 1, every mask and compare byte is 0, and the interrupt mode is latched.
- R2: Alarm k (k = 0, 1) uses register addresses 8k..8k+6 for the compare bytes of fields 0..6 and address 8k+7 for its mask byte, where mask bit f enables field f. On a clock edge where `tick_i` is 1 and every enabled field equals its compare byte, `flag_o[k]` reads 1 after that edge. A tick where an enabled field differs leaves the flag unchanged.
- R3: A field whose mask bit is 0 has no influence on the match, whatever its compare byte holds.
- R4: An alarm whose mask byte is 0 never sets its flag, even when every compare byte equals the time.
- R5: Without `tick_i`, no flag is set and no pulse is produced, however long the time matches.
- R6: In latched mode (address 16, bit 0 = 0), `irq_n_o` is 0 exactly while either flag is set. Writing address 17 with bit k = 0 clears `flag_o[k]`. Writing bit k = 1 leaves the flag as it is.
- R7: In pulse mode (address 16, bit 0 = 1), `irq_n_o` is 0 for exactly the one clock cycle after a matching tick edge. The flag still sets as in R2.
- R8: The two alarms are independent. A match sets only that alarm's flag, and the interrupt line responds to either alarm.
- R9: When a match and a clear of the same flag happen in the same cycle, the flag ends up set.
- R10: In pulse mode, an alarm that compares only seconds pulses exactly once for each full sweep of seconds 00..59.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-second tick, one clock wide, with the time fields already updated |
| time_i | input | 56 | Current time, seven BCD bytes, seconds in the low byte |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 8 | Register write data |
| flag_o | output | 2 | Per-alarm status flags |
| irq_n_o | output | 1 | Active-low combined interrupt |

## Verification
The bench tries several time patterns:
- A full seven-field match separates a correct all-field compare from one that ignores some fields.
- A minutes-only mask, with the other fields deliberately wrong, shows that masked fields are ignored. One differing minute value then shows that enabled fields still decide the match.
- Compare bytes that equal the time under a zero mask separate "no mask means never" from "no mask means always".
- A held match with no tick exposes a comparator that is not gated by the tick.
- A 120-tick seconds sweep in pulse mode counts pulses. It tells one pulse per minute apart from a level or repeated pulses.
- A match and a clear in the same cycle shows the priority between them.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned ALM_COUNT  = 2;
  localparam int unsigned ALM_FIELDS = 7;
  localparam int unsigned ALM_BYTE_W = 8;
  localparam int unsigned ALM_ADDR_W = 5;

  typedef enum logic {
    IRQ_LATCHED = 1'b0,
    IRQ_PULSE   = 1'b1
  } irq_mode_e;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5,
    FLD_DOW   = 3'd6
  } time_field_e;
endpackage

// File: rtl/alarm_rst_sync.sv
module alarm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/alarm_bank.sv
module alarm_bank #(
  parameter int unsigned NUM_FIELDS = alarm_pkg::ALM_FIELDS,
  parameter int unsigned BYTE_W     = alarm_pkg::ALM_BYTE_W,
  parameter int unsigned ADDR_W     = alarm_pkg::ALM_ADDR_W,
  parameter int unsigned BASE_ADDR  = 0
) (
  input  logic                         clk,
  input  logic                         srst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [NUM_FIELDS*BYTE_W-1:0] time_flat,
  output logic [NUM_FIELDS-1:0]        mask_o,
  output logic                         hit_o
);
  localparam int unsigned MASK_ADDR = BASE_ADDR + NUM_FIELDS;

  logic [NUM_FIELDS-1:0] mask_q;
  logic [NUM_FIELDS-1:0] mask_d;
  logic                  mask_en;
  logic [NUM_FIELDS-1:0] field_eq;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [BYTE_W-1:0] cmp_q;
    logic [BYTE_W-1:0] cmp_d;
    logic              cmp_en;

    always_comb begin
      cmp_en = wr_en && (wr_addr == ADDR_W'(BASE_ADDR + f));
      cmp_d  = wr_data;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)     cmp_q <= '0;
      else if (cmp_en) cmp_q <= cmp_d;
    end

    assign field_eq[f] = (time_flat[f*BYTE_W +: BYTE_W] == cmp_q);
  end

  always_comb begin
    mask_en = wr_en && (wr_addr == ADDR_W'(MASK_ADDR));
    mask_d  = wr_data[NUM_FIELDS-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign hit_o  = (|mask_q) && (&(field_eq | ~mask_q));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int unsigned NUM_ALARMS = alarm_pkg::ALM_COUNT,
  parameter int unsigned BYTE_W     = alarm_pkg::ALM_BYTE_W,
  parameter int unsigned ADDR_W     = alarm_pkg::ALM_ADDR_W,
  parameter int unsigned CTRL_ADDR  = 16,
  parameter int unsigned STAT_ADDR  = 17
) (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  tick,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [NUM_ALARMS-1:0] hit,
  output logic [NUM_ALARMS-1:0] flag_o,
  output logic                  pulse_mode_o,
  output logic                  irq_n_o
);
  import alarm_pkg::*;

  logic [NUM_ALARMS-1:0] flag_q, flag_d, evt, clr;
  irq_mode_e             mode_q, mode_d;
  logic                  mode_en;
  logic                  pulse_q, pulse_d;

  always_comb begin
    evt     = tick ? hit : '0;
    clr     = (wr_en && (wr_addr == ADDR_W'(STAT_ADDR))) ? ~wr_data[NUM_ALARMS-1:0] : '0;
    flag_d  = (flag_q & ~clr) | evt;
    mode_en = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    mode_d  = irq_mode_e'(wr_data[0]);
    pulse_d = |evt;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      flag_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      mode_q <= IRQ_LATCHED;
    else if (mode_en) mode_q <= mode_d;
  end

  assign flag_o       = flag_q;
  assign pulse_mode_o = (mode_q == IRQ_PULSE);
  assign irq_n_o      = (mode_q == IRQ_PULSE) ? ~pulse_q : ~(|flag_q);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int unsigned NUM_ALARMS = alarm_pkg::ALM_COUNT,
  parameter int unsigned NUM_FIELDS = alarm_pkg::ALM_FIELDS,
  parameter int unsigned BYTE_W     = alarm_pkg::ALM_BYTE_W,
  parameter int unsigned ADDR_W     = alarm_pkg::ALM_ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_i,
  input  logic [NUM_FIELDS*BYTE_W-1:0] time_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  output logic [NUM_ALARMS-1:0]        flag_o,
  output logic                         irq_n_o
);
  localparam int unsigned STRIDE    = 1 << $clog2(NUM_FIELDS + 1);
  localparam int unsigned CTRL_ADDR = NUM_ALARMS * STRIDE;
  localparam int unsigned STAT_ADDR = CTRL_ADDR + 1;

  logic                             srst_n;
  logic [NUM_ALARMS-1:0]            hit;
  logic [NUM_ALARMS*NUM_FIELDS-1:0] mask_flat;
  logic                             pulse_mode;

  alarm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_bank
    alarm_bank #(
      .NUM_FIELDS (NUM_FIELDS),
      .BYTE_W     (BYTE_W),
      .ADDR_W     (ADDR_W),
      .BASE_ADDR  (k * STRIDE)
    ) u_bank (
      .clk       (clk),
      .srst_n    (srst_n),
      .wr_en     (wr_en_i),
      .wr_addr   (wr_addr_i),
      .wr_data   (wr_data_i),
      .time_flat (time_i),
      .mask_o    (mask_flat[k*NUM_FIELDS +: NUM_FIELDS]),
      .hit_o     (hit[k])
    );
  end

  alarm_irq_ctrl #(
    .NUM_ALARMS (NUM_ALARMS),
    .BYTE_W     (BYTE_W),
    .ADDR_W     (ADDR_W),
    .CTRL_ADDR  (CTRL_ADDR),
    .STAT_ADDR  (STAT_ADDR)
  ) u_irq (
    .clk          (clk),
    .srst_n       (srst_n),
    .tick         (tick_i),
    .wr_en        (wr_en_i),
    .wr_addr      (wr_addr_i),
    .wr_data      (wr_data_i),
    .hit          (hit),
    .flag_o       (flag_o),
    .pulse_mode_o (pulse_mode),
    .irq_n_o      (irq_n_o)
  );
endmodule

// File: rtl/alarm_match_checker.sv
module alarm_match_checker #(
  parameter int unsigned NUM_ALARMS = 2,
  parameter int unsigned NUM_FIELDS = 7,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned STAT_ADDR  = 17
) (
  input logic                             clk,
  input logic                             srst_n,
  input logic                             tick_i,
  input logic                             wr_en_i,
  input logic [ADDR_W-1:0]                wr_addr_i,
  input logic [BYTE_W-1:0]                wr_data_i,
  input logic [NUM_ALARMS-1:0]            flag_o,
  input logic                             irq_n_o,
  input logic                             pulse_mode,
  input logic [NUM_ALARMS*NUM_FIELDS-1:0] mask_flat,
  input logic [NUM_ALARMS-1:0]            hit
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !srst_n |-> (flag_o == '0) && irq_n_o); // R1

  AST_PULSE_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!srst_n)
    (pulse_mode && !irq_n_o) |-> $past(tick_i)); // R7

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_chk
    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!srst_n)
      $rose(flag_o[k]) |-> $past(tick_i)); // R5

    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
      $fell(flag_o[k]) |-> $past(wr_en_i && (wr_addr_i == ADDR_W'(STAT_ADDR)) && !wr_data_i[k])); // R6

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!srst_n)
      (tick_i && hit[k]) |=> flag_o[k]); // R2

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
      (tick_i && hit[k] && wr_en_i && (wr_addr_i == ADDR_W'(STAT_ADDR)) && !wr_data_i[k]) |=> flag_o[k]); // R9

    AST_EMPTY_MASK_SILENT: assert property (@(posedge clk) disable iff (!srst_n)
      ((mask_flat[k*NUM_FIELDS +: NUM_FIELDS] == '0) && !flag_o[k]) |=> !flag_o[k]); // R4
  end
endmodule

bind alarm_match_unit alarm_match_checker #(
  .NUM_ALARMS (NUM_ALARMS),
  .NUM_FIELDS (NUM_FIELDS),
  .BYTE_W     (BYTE_W),
  .ADDR_W     (ADDR_W),
  .STAT_ADDR  (STAT_ADDR)
) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .flag_o     (flag_o),
  .irq_n_o    (irq_n_o),
  .pulse_mode (pulse_mode),
  .mask_flat  (mask_flat),
  .hit        (hit)
);

// File: tb/tb_alarm_match_unit.sv
module tb_alarm_match_unit;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic [55:0] time_i;
  logic        wr_en_i;
  logic [4:0]  wr_addr_i;
  logic [7:0]  wr_data_i;
  logic [1:0]  flag_o;
  logic        irq_n_o;

  int n_checks = 0;
  int n_fails  = 0;

  alarm_match_unit dut (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .time_i (time_i),
    .wr_en_i (wr_en_i), .wr_addr_i (wr_addr_i), .wr_data_i (wr_data_i),
    .flag_o (flag_o), .irq_n_o (irq_n_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 5'(addr); wr_data_i = 8'(data);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int d,
                          input int mo, input int y, input int w);
    time_i = {bcd(w), bcd(y), bcd(mo), bcd(d), bcd(h), bcd(mi), bcd(s)};
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic program_alarm(input int k, input int s, input int mi, input int h,
                               input int d, input int mo, input int y, input int w,
                               input int mask);
    wr(k*8+0, bcd(s)); wr(k*8+1, bcd(mi)); wr(k*8+2, bcd(h)); wr(k*8+3, bcd(d));
    wr(k*8+4, bcd(mo)); wr(k*8+5, bcd(y)); wr(k*8+6, bcd(w)); wr(k*8+7, mask);
  endtask

  task automatic t_reset();
    check("R1 flags after reset", flag_o, 0);
    check("R1 irq_n after reset", irq_n_o, 1);
    set_time(0, 0, 0, 0, 0, 0, 0);
    pulse_tick();
    check("R1/R4 zero registers do not fire", flag_o, 0);
    check("R1 latched irq idle", irq_n_o, 1);
  endtask

  task automatic t_full_match();
    program_alarm(0, 45, 30, 12, 25, 12, 24, 3, 8'h7F);
    set_time(45, 30, 12, 25, 12, 24, 3);
    pulse_tick();
    check("R2 full match sets flag0", flag_o, 1);
    check("R6 latched irq low", irq_n_o, 0);
    repeat (5) @(negedge clk);
    check("R6 flag held", flag_o, 1);
    wr(17, 8'h03);
    check("R6 write 1 keeps flag", flag_o, 1);
    wr(17, 8'h02);
    check("R6 write 0 clears flag0", flag_o, 0);
    check("R6 irq released", irq_n_o, 1);
    set_time(46, 30, 12, 25, 12, 24, 3);
    pulse_tick();
    check("R2 one field differs no fire", flag_o, 0);
  endtask

  task automatic t_subset();
    program_alarm(0, 11, 30, 22, 1, 1, 1, 1, 8'h02);
    set_time(59, 30, 7, 9, 9, 99, 5);
    pulse_tick();
    check("R3 minutes-only match ignores others", flag_o, 1);
    wr(17, 8'h00);
    set_time(59, 31, 7, 9, 9, 99, 5);
    pulse_tick();
    check("R2 enabled minute differs", flag_o, 0);
  endtask

  task automatic t_no_tick();
    set_time(0, 30, 0, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    check("R5 no tick no flag", flag_o, 0);
    check("R5 no tick irq idle", irq_n_o, 1);
  endtask

  task automatic t_mask_zero();
    program_alarm(1, 5, 6, 7, 8, 9, 10, 2, 8'h00);
    set_time(5, 6, 7, 8, 9, 10, 2);
    pulse_tick();
    check("R4 zero mask never fires", flag_o[1], 0);
  endtask

  task automatic t_pulse();
    wr(17, 8'h00);
    wr(7, 8'h00);
    wr(16, 8'h01);
    program_alarm(1, 15, 0, 0, 0, 0, 0, 0, 8'h01);
    set_time(15, 44, 3, 3, 3, 3, 3);
    pulse_tick();
    check("R7 pulse low after tick", irq_n_o, 0);
    check("R8 only alarm1 flag", flag_o, 2);
    @(negedge clk);
    check("R7 pulse one cycle", irq_n_o, 1);
    check("R7 flag remains in pulse mode", flag_o, 2);
  endtask

  task automatic t_periodic();
    int lows = 0;
    wr(17, 8'h00);
    for (int n = 0; n < 120; n++) begin
      @(negedge clk);
      set_time(n % 60, 10, 3, 3, 3, 3, 3);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      if (!irq_n_o) lows++;
    end
    check("R10 one pulse per minute sweep", lows, 2);
  endtask

  task automatic t_both();
    wr(16, 8'h00);
    wr(17, 8'h00);
    program_alarm(0, 20, 0, 0, 0, 0, 0, 0, 8'h01);
    program_alarm(1, 0, 0, 0, 0, 0, 0, 4, 8'h40);
    set_time(20, 1, 1, 1, 1, 1, 4);
    pulse_tick();
    check("R8 both flags", flag_o, 3);
    wr(17, 8'h02);
    check("R8 clear alarm0 only", flag_o, 2);
    check("R8 irq still low", irq_n_o, 0);
    wr(17, 8'h00);
  endtask

  task automatic t_set_wins();
    set_time(20, 1, 1, 1, 1, 1, 0);
    pulse_tick();
    check("R9 setup flag0", flag_o, 1);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 5'd17; wr_data_i = 8'h00;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R9 set beats clear", flag_o, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; time_i = '0;
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_match();
    t_subset();
    t_no_tick();
    t_mask_zero();
    t_pulse();
    t_periodic();
    t_both();
    t_set_wins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule